// File: doc/BRIEF.md
# Unicast/Multicast Cell Dispatch Scheduler

This block sits at the egress of an input port, between two cell queues and the switching fabric. In every cycle in which the fabric is not congested, it picks one cell from either the unicast queue head or the multicast queue head. It builds the 32-bit routing header for that cell and presents the header, together with a payload handle, on a registered output. A head cell is consumed through a pop strobe.

The choice between the two traffic types uses a turn counter. The configured share gives unicast a fixed number of send opportunities for every single multicast opportunity. The scheduler is work-conserving: when the type whose turn it is has nothing waiting, the other type is sent instead.

Multicast packets are expanded in place. The head cell's group number selects a row of a destination table, and the cell is sent once to each destination of that row in index order. Only then is the cell popped, and the next cell of the packet is expanded the same way.

Top module: `cell_dispatch_sched`

## Requirements
- R1: A send decided in cycle t appears on `out_valid`, `out_hdr` and `out_handle` in cycle t+1. The header layout is `[31:23]` source port (from `src_port`), `[22:14]` packet number, `[13:9]` cell sequence number and `[8:0]` destination port.
- R2: A unicast send copies `uc_pkt_id`, `uc_seq`, `uc_dest` and `uc_handle` of the queue head into the header and handle, and asserts `uc_pop` in the decision cycle.
- R3: A multicast copy takes its destination from table entry (group, index), stored at `mc_tbl_dest[(group*MAX_DEST+index)*9 +: 9]`. The copies of one cell go out in index order 0, 1, ..., n-1, where n is `mc_tbl_cnt[group*CNT_W +: CNT_W]` (1 to MAX_DEST).
- R4: `mc_pop` is asserted only together with the send of the copy for the last destination index of the head cell. The next multicast copy after that starts again at index 0.
- R5: The turn counter starts at 0, counts up by one on each send made in a unicast turn, and returns to 0 on each send made in a multicast turn. It is a multicast turn when the count is at least `cfg_uc_ratio`. With both queues always ready and ratio R, the send pattern is R unicast cells followed by one multicast copy, repeated.
- R6: When the fabric is ready and the turn's type has no valid head but the other type has one, the other type is sent. Exactly one of `uc_pop` or a multicast copy happens in every ready cycle with at least one valid head.
- R7: In a cycle with `fab_ready` low, no pop occurs and `out_valid` is low in the next cycle. The turn counter and fan-out index keep their values.
- R8: With `cfg_uc_ratio` = 0, every turn is a multicast turn, so unicast cells are sent only while the multicast head is not valid.
- R9: After reset `out_valid` is low, the turn counter is 0 (a unicast turn when the ratio is nonzero) and the fan-out index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_port | input | 9 | Number of this input port, placed in every header |
| cfg_uc_ratio | input | RATIO_W | Unicast turns per multicast turn |
| fab_ready | input | 1 | Fabric accepts a cell this cycle (not congested) |
| uc_valid | input | 1 | Unicast queue head is valid |
| uc_pkt_id | input | 9 | Unicast head packet number |
| uc_seq | input | 5 | Unicast head cell sequence number |
| uc_dest | input | 9 | Unicast head destination port |
| uc_handle | input | HANDLE_W | Unicast head payload handle |
| uc_pop | output | 1 | Unicast head consumed this cycle |
| mc_valid | input | 1 | Multicast queue head is valid |
| mc_pkt_id | input | 9 | Multicast head packet number |
| mc_seq | input | 5 | Multicast head cell sequence number |
| mc_group | input | GROUP_W | Multicast head group number |
| mc_handle | input | HANDLE_W | Multicast head payload handle |
| mc_pop | output | 1 | Multicast head released this cycle |
| mc_tbl_dest | input | 2**GROUP_W*MAX_DEST*9 | Destination table, one 9-bit port per (group, index) |
| mc_tbl_cnt | input | 2**GROUP_W*CNT_W | Destination count per group |
| out_valid | output | 1 | A cell is launched into the fabric |
| out_hdr | output | 32 | Header of the launched cell |
| out_handle | output | HANDLE_W | Payload handle of the launched cell |

## Verification
The assertions assume that the queue heads behave like FIFO outputs. Their fields are stable while valid, and a head changes only after its pop. They also assume the group counts lie between 1 and MAX_DEST and that the table does not change while a multicast cell is partly expanded. The stimulus keeps within these limits in three ways. Queue heads are driven from bench-side arrays that advance only on the observed pop strobes. Table counts are drawn from 1 to MAX_DEST. The table is rewritten only after both queues have drained, when the fan-out index is back at 0. The random congestion, valid gating and ratio settings then exercise the turn and fan-out corners within those limits.

// File: rtl/cds_pkg.sv
package cds_pkg;

    localparam int PORT_W = 9;
    localparam int PKT_W  = 9;
    localparam int SEQ_W  = 5;
    localparam int HDR_W  = PORT_W + PKT_W + SEQ_W + PORT_W;

    typedef struct packed {
        logic [PORT_W-1:0] src;
        logic [PKT_W-1:0]  pkt;
        logic [SEQ_W-1:0]  seq;
        logic [PORT_W-1:0] dst;
    } cell_hdr_t;

    typedef enum logic {
        TURN_UC = 1'b0,
        TURN_MC = 1'b1
    } turn_e;

endpackage

// File: rtl/cds_turn_ctrl.sv
module cds_turn_ctrl
    import cds_pkg::*;
#(
    parameter int RATIO_W = 4
) (
    input  logic [RATIO_W-1:0] ratio,
    input  logic [RATIO_W-1:0] cnt_q,
    input  logic               fab_ready,
    input  logic               uc_valid,
    input  logic               mc_valid,
    output logic               pick_uc,
    output logic               pick_mc,
    output logic [RATIO_W-1:0] cnt_d
);

    turn_e turn;
    logic  sending;

    always_comb begin
        turn    = (cnt_q >= ratio) ? TURN_MC : TURN_UC;
        pick_mc = fab_ready && mc_valid && ((turn == TURN_MC) || !uc_valid);
        pick_uc = fab_ready && uc_valid && !pick_mc;
        sending = pick_uc || pick_mc;
        cnt_d   = cnt_q;
        if (sending) begin
            if (turn == TURN_MC) begin
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cds_fanout_sel.sv
module cds_fanout_sel
    import cds_pkg::*;
#(
    parameter int GROUP_W  = 3,
    parameter int MAX_DEST = 4,
    parameter int IDX_W    = 2,
    parameter int CNT_W    = 3
) (
    input  logic [GROUP_W-1:0]                     group,
    input  logic [IDX_W-1:0]                       idx_q,
    input  logic [(2**GROUP_W)*MAX_DEST*PORT_W-1:0] tbl_dest,
    input  logic [(2**GROUP_W)*CNT_W-1:0]           tbl_cnt,
    input  logic                                   advance,
    output logic [PORT_W-1:0]                      dest,
    output logic                                   last,
    output logic [IDX_W-1:0]                       idx_d
);

    localparam int ROW_W = MAX_DEST * PORT_W;

    logic [ROW_W-1:0]  row;
    logic [PORT_W-1:0] row_ent [MAX_DEST];
    logic [CNT_W-1:0]  n_dest;
    logic [CNT_W:0]    idx_next_ext;
    logic [CNT_W:0]    n_ext;

    assign row    = tbl_dest[group*ROW_W +: ROW_W];
    assign n_dest = tbl_cnt[group*CNT_W +: CNT_W];

    for (genvar gi = 0; gi < MAX_DEST; gi++) begin : g_row_split
        assign row_ent[gi] = row[gi*PORT_W +: PORT_W];
    end

    always_comb begin
        dest = row_ent[0];
        for (int k = 0; k < MAX_DEST; k++) begin
            if (idx_q == IDX_W'(k)) begin
                dest = row_ent[k];
            end
        end
        idx_next_ext = {{(CNT_W + 1 - IDX_W){1'b0}}, idx_q} + (CNT_W + 1)'(1);
        n_ext        = {1'b0, n_dest};
        last         = (idx_next_ext >= n_ext);
        idx_d        = idx_q;
        if (advance) begin
            idx_d = last ? '0 : (idx_q + 1'b1);
        end
    end

endmodule

// File: rtl/cell_dispatch_sched.sv
module cell_dispatch_sched
    import cds_pkg::*;
#(
    parameter int HANDLE_W = 10,
    parameter int GROUP_W  = 3,
    parameter int MAX_DEST = 4,
    parameter int RATIO_W  = 4,
    parameter int CNT_W    = $clog2(MAX_DEST + 1)
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [PORT_W-1:0]                      src_port,
    input  logic [RATIO_W-1:0]                     cfg_uc_ratio,
    input  logic                                   fab_ready,
    input  logic                                   uc_valid,
    input  logic [PKT_W-1:0]                       uc_pkt_id,
    input  logic [SEQ_W-1:0]                       uc_seq,
    input  logic [PORT_W-1:0]                      uc_dest,
    input  logic [HANDLE_W-1:0]                    uc_handle,
    output logic                                   uc_pop,
    input  logic                                   mc_valid,
    input  logic [PKT_W-1:0]                       mc_pkt_id,
    input  logic [SEQ_W-1:0]                       mc_seq,
    input  logic [GROUP_W-1:0]                     mc_group,
    input  logic [HANDLE_W-1:0]                    mc_handle,
    output logic                                   mc_pop,
    input  logic [(2**GROUP_W)*MAX_DEST*PORT_W-1:0] mc_tbl_dest,
    input  logic [(2**GROUP_W)*CNT_W-1:0]           mc_tbl_cnt,
    output logic                                   out_valid,
    output logic [HDR_W-1:0]                       out_hdr,
    output logic [HANDLE_W-1:0]                    out_handle
);

    localparam int IDX_W = (MAX_DEST > 1) ? $clog2(MAX_DEST) : 1;

    typedef struct packed {
        logic                out_valid;
        cell_hdr_t           hdr;
        logic [HANDLE_W-1:0] handle;
        logic [RATIO_W-1:0]  cnt;
        logic [IDX_W-1:0]    idx;
    } state_t;

    state_t st_q, st_d;

    logic               pick_uc, pick_mc;
    logic [RATIO_W-1:0] cnt_nx;
    logic [PORT_W-1:0]  fan_dest;
    logic               fan_last;
    logic [IDX_W-1:0]   idx_nx;

    cds_turn_ctrl #(
        .RATIO_W (RATIO_W)
    ) u_turn (
        .ratio     (cfg_uc_ratio),
        .cnt_q     (st_q.cnt),
        .fab_ready (fab_ready),
        .uc_valid  (uc_valid),
        .mc_valid  (mc_valid),
        .pick_uc   (pick_uc),
        .pick_mc   (pick_mc),
        .cnt_d     (cnt_nx)
    );

    cds_fanout_sel #(
        .GROUP_W  (GROUP_W),
        .MAX_DEST (MAX_DEST),
        .IDX_W    (IDX_W),
        .CNT_W    (CNT_W)
    ) u_fanout (
        .group    (mc_group),
        .idx_q    (st_q.idx),
        .tbl_dest (mc_tbl_dest),
        .tbl_cnt  (mc_tbl_cnt),
        .advance  (pick_mc),
        .dest     (fan_dest),
        .last     (fan_last),
        .idx_d    (idx_nx)
    );

    always_comb begin
        st_d           = st_q;
        st_d.cnt       = cnt_nx;
        st_d.idx       = idx_nx;
        st_d.out_valid = pick_uc || pick_mc;
        if (pick_uc) begin
            st_d.hdr.src = src_port;
            st_d.hdr.pkt = uc_pkt_id;
            st_d.hdr.seq = uc_seq;
            st_d.hdr.dst = uc_dest;
            st_d.handle  = uc_handle;
        end else if (pick_mc) begin
            st_d.hdr.src = src_port;
            st_d.hdr.pkt = mc_pkt_id;
            st_d.hdr.seq = mc_seq;
            st_d.hdr.dst = fan_dest;
            st_d.handle  = mc_handle;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign uc_pop     = pick_uc;
    assign mc_pop     = pick_mc && fan_last;
    assign out_valid  = st_q.out_valid;
    assign out_hdr    = st_q.hdr;
    assign out_handle = st_q.handle;

endmodule

// File: rtl/cds_dispatch_chk.sv
module cds_dispatch_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        fab_ready,
    input logic        uc_valid,
    input logic        mc_valid,
    input logic        uc_pop,
    input logic        mc_pop,
    input logic [8:0]  uc_dest,
    input logic [8:0]  src_port,
    input logic        out_valid,
    input logic [31:0] out_hdr
);

    AST_POP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(uc_pop && mc_pop)); // R6

    AST_NO_POP_CONGESTED: assert property (@(posedge clk) disable iff (!rst_n)
        !fab_ready |-> (!uc_pop && !mc_pop)); // R7

    AST_IDLE_AFTER_CONGESTED: assert property (@(posedge clk) disable iff (!rst_n)
        !fab_ready |=> !out_valid); // R7

    AST_WORK_CONSERVING: assert property (@(posedge clk) disable iff (!rst_n)
        (fab_ready && (uc_valid || mc_valid)) |=> out_valid); // R6

    AST_UC_DEST_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        uc_pop |=> (out_hdr[8:0] == $past(uc_dest))); // R2

    AST_SRC_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (uc_pop || (fab_ready && mc_valid)) |=> (out_hdr[31:23] == $past(src_port))); // R1

    AST_POP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (uc_pop |-> uc_valid) and (mc_pop |-> mc_valid)); // R4

endmodule

bind cell_dispatch_sched cds_dispatch_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fab_ready (fab_ready),
    .uc_valid  (uc_valid),
    .mc_valid  (mc_valid),
    .uc_pop    (uc_pop),
    .mc_pop    (mc_pop),
    .uc_dest   (uc_dest),
    .src_port  (src_port),
    .out_valid (out_valid),
    .out_hdr   (out_hdr)
);

// File: tb/cell_dispatch_sched_tb.sv
module cell_dispatch_sched_tb;

    localparam int HANDLE_W = 10;
    localparam int GROUP_W  = 3;
    localparam int MAX_DEST = 4;
    localparam int RATIO_W  = 4;
    localparam int CNT_W    = 3;
    localparam int NGRP     = 8;
    localparam int QDEPTH   = 512;

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic [8:0]                 src_port = 9'd0;
    logic [RATIO_W-1:0]         cfg_uc_ratio = '0;
    logic                       fab_ready = 1'b0;
    logic                       uc_valid = 1'b0;
    logic [8:0]                 uc_pkt_id = '0;
    logic [4:0]                 uc_seq = '0;
    logic [8:0]                 uc_dest = '0;
    logic [HANDLE_W-1:0]        uc_handle = '0;
    logic                       uc_pop;
    logic                       mc_valid = 1'b0;
    logic [8:0]                 mc_pkt_id = '0;
    logic [4:0]                 mc_seq = '0;
    logic [GROUP_W-1:0]         mc_group = '0;
    logic [HANDLE_W-1:0]        mc_handle = '0;
    logic                       mc_pop;
    logic [NGRP*MAX_DEST*9-1:0] mc_tbl_dest = '0;
    logic [NGRP*CNT_W-1:0]      mc_tbl_cnt = '0;
    logic                       out_valid;
    logic [31:0]                out_hdr;
    logic [HANDLE_W-1:0]        out_handle;

    always #10 clk = ~clk;

    cell_dispatch_sched #(
        .HANDLE_W (HANDLE_W),
        .GROUP_W  (GROUP_W),
        .MAX_DEST (MAX_DEST),
        .RATIO_W  (RATIO_W)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_port     (src_port),
        .cfg_uc_ratio (cfg_uc_ratio),
        .fab_ready    (fab_ready),
        .uc_valid     (uc_valid),
        .uc_pkt_id    (uc_pkt_id),
        .uc_seq       (uc_seq),
        .uc_dest      (uc_dest),
        .uc_handle    (uc_handle),
        .uc_pop       (uc_pop),
        .mc_valid     (mc_valid),
        .mc_pkt_id    (mc_pkt_id),
        .mc_seq       (mc_seq),
        .mc_group     (mc_group),
        .mc_handle    (mc_handle),
        .mc_pop       (mc_pop),
        .mc_tbl_dest  (mc_tbl_dest),
        .mc_tbl_cnt   (mc_tbl_cnt),
        .out_valid    (out_valid),
        .out_hdr      (out_hdr),
        .out_handle   (out_handle)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // bench-side queue contents
    logic [8:0]          uq_pkt [QDEPTH];
    logic [4:0]          uq_seq [QDEPTH];
    logic [8:0]          uq_dst [QDEPTH];
    logic [HANDLE_W-1:0] uq_hdl [QDEPTH];
    logic [8:0]          mq_pkt [QDEPTH];
    logic [4:0]          mq_seq [QDEPTH];
    logic [GROUP_W-1:0]  mq_grp [QDEPTH];
    logic [HANDLE_W-1:0] mq_hdl [QDEPTH];
    int uc_n = 0, uc_rd = 0, mc_n = 0, mc_rd = 0;

    // reference model state
    int          m_cnt = 0;
    int          m_idx = 0;
    logic        e_valid = 1'b0;
    logic [31:0] e_hdr = '0;
    logic [HANDLE_W-1:0] e_hdl = '0;
    string       e_tag = "R1";
    int          uc_sent = 0;
    int          mc_copies = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_hdr(input logic [8:0] p, input logic [4:0] s,
                                           input logic [8:0] d);
        return {src_port, p, s, d};
    endfunction

    function automatic logic [8:0] tbl_ent(input int g, input int i);
        return mc_tbl_dest[(g*MAX_DEST+i)*9 +: 9];
    endfunction

    function automatic int tbl_n(input int g);
        return int'(mc_tbl_cnt[g*CNT_W +: CNT_W]);
    endfunction

    task automatic fill(input int nu, input int nm);
        uc_n = nu; uc_rd = 0; mc_n = nm; mc_rd = 0;
        for (int i = 0; i < QDEPTH; i++) begin
            uq_pkt[i] = 9'($urandom); uq_seq[i] = 5'($urandom_range(0, 23));
            uq_dst[i] = 9'($urandom); uq_hdl[i] = HANDLE_W'($urandom);
            mq_pkt[i] = 9'($urandom); mq_seq[i] = 5'($urandom_range(0, 23));
            mq_grp[i] = GROUP_W'($urandom); mq_hdl[i] = HANDLE_W'($urandom);
        end
    endtask

    task automatic new_table();
        for (int g = 0; g < NGRP; g++) begin
            mc_tbl_cnt[g*CNT_W +: CNT_W] = CNT_W'($urandom_range(1, MAX_DEST));
            for (int i = 0; i < MAX_DEST; i++) begin
                mc_tbl_dest[(g*MAX_DEST+i)*9 +: 9] = 9'($urandom);
            end
        end
    endtask

    // one cycle: check registered output, drive heads, check pops, advance model
    task automatic step(input bit fr, input bit ue, input bit me);
        bit uv, mv, turn_mc, pm, pu, last;
        int g;
        string tag;
        @(negedge clk);
        chk(out_valid == e_valid, e_tag, "out_valid", 32'(out_valid), 32'(e_valid));
        if (e_valid) begin
            chk(out_hdr == e_hdr, e_tag, "out_hdr", out_hdr, e_hdr);
            chk(out_handle == e_hdl, "R2", "out_handle", 32'(out_handle), 32'(e_hdl));
        end
        uv = ue && (uc_rd < uc_n);
        mv = me && (mc_rd < mc_n);
        fab_ready = fr;
        uc_valid  = uv;
        mc_valid  = mv;
        uc_pkt_id = uv ? uq_pkt[uc_rd] : '0;
        uc_seq    = uv ? uq_seq[uc_rd] : '0;
        uc_dest   = uv ? uq_dst[uc_rd] : '0;
        uc_handle = uv ? uq_hdl[uc_rd] : '0;
        mc_pkt_id = mv ? mq_pkt[mc_rd] : '0;
        mc_seq    = mv ? mq_seq[mc_rd] : '0;
        mc_group  = mv ? mq_grp[mc_rd] : '0;
        mc_handle = mv ? mq_hdl[mc_rd] : '0;
        #1;
        turn_mc = (m_cnt >= int'(cfg_uc_ratio));
        pm = fr && mv && (turn_mc || !uv);
        pu = fr && uv && !pm;
        g  = int'(mc_group);
        last = (m_idx + 1 >= tbl_n(g));
        if (!fr) tag = "R7";
        else if ((turn_mc && !mv) || (!turn_mc && !uv)) tag = "R6";
        else if (cfg_uc_ratio == 0) tag = "R8";
        else tag = "R5";
        chk(uc_pop == pu, tag, "uc_pop", 32'(uc_pop), 32'(pu));
        chk(mc_pop == (pm && last), (pm ? "R4" : tag), "mc_pop", 32'(mc_pop), 32'(pm && last));
        e_valid = pu || pm;
        e_tag   = fr ? "R1" : "R7";
        if (pu) begin
            e_hdr = mk_hdr(uc_pkt_id, uc_seq, uc_dest);
            e_hdl = uc_handle;
            e_tag = "R2";
            uc_rd++;
            uc_sent++;
        end else if (pm) begin
            e_hdr = mk_hdr(mc_pkt_id, mc_seq, tbl_ent(g, m_idx));
            e_hdl = mc_handle;
            e_tag = "R3";
            mc_copies++;
            if (last) begin
                m_idx = 0;
                mc_rd++;
            end else begin
                m_idx++;
            end
        end
        if (pu || pm) m_cnt = turn_mc ? 0 : m_cnt + 1;
    endtask

    task automatic drain();
        for (int i = 0; i < 6000; i++) begin
            if (uc_rd >= uc_n && mc_rd >= mc_n) break;
            step(1'b1, 1'b1, 1'b1);
        end
        step(1'b1, 1'b1, 1'b1);
    endtask

    task automatic rand_phase(input int ratio, input int cycles, input int fr_pct,
                              input int en_pct);
        cfg_uc_ratio = RATIO_W'(ratio);
        new_table();
        fill(200, 120);
        for (int c = 0; c < cycles; c++) begin
            step($urandom_range(0, 99) < fr_pct,
                 $urandom_range(0, 99) < en_pct,
                 $urandom_range(0, 99) < en_pct);
        end
        drain();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        src_port = 9'd301;
        cfg_uc_ratio = 4'd3;
        new_table();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        chk(out_valid == 1'b0, "R9", "out_valid after reset", 32'(out_valid), 32'd0);

        // R9: first turn after reset is unicast, first copy uses index 0
        fill(4, 4);
        step(1'b1, 1'b1, 1'b1);
        chk(uc_sent == 1, "R9", "first send is unicast", 32'(uc_sent), 32'd1);
        drain();

        // R5: ratio 3 with both queues always ready -> 3 of every 4 sends unicast
        fill(300, 300);
        uc_sent = 0; mc_copies = 0; m_cnt = m_cnt;
        drain();
        // restart the turn from a known place through reset
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        m_cnt = 0; m_idx = 0; e_valid = 1'b0;
        fill(300, 300);
        uc_sent = 0; mc_copies = 0;
        for (int c = 0; c < 40; c++) step(1'b1, 1'b1, 1'b1);
        chk(uc_sent == 30, "R5", "unicast sends in 40 slots", 32'(uc_sent), 32'd30);
        chk(mc_copies == 10, "R5", "multicast copies in 40 slots", 32'(mc_copies), 32'd10);
        drain();

        // R7: congestion freezes everything, then traffic resumes in order
        fill(10, 10);
        for (int c = 0; c < 3; c++) step(1'b1, 1'b0, 1'b1);
        uc_sent = 0; mc_copies = 0;
        for (int c = 0; c < 20; c++) step(1'b0, 1'b1, 1'b1);
        chk((uc_sent + mc_copies) == 0, "R7", "sends under congestion",
            32'(uc_sent + mc_copies), 32'd0);
        drain();

        // R8: ratio 0 -> multicast drains before any unicast
        cfg_uc_ratio = 4'd0;
        fill(20, 15);
        uc_sent = 0;
        for (int c = 0; c < 15; c++) step(1'b1, 1'b1, 1'b1);
        chk(uc_sent == 0, "R8", "unicast sends while multicast waits", 32'(uc_sent), 32'd0);
        drain();

        // R6: only one type present at a multicast turn
        cfg_uc_ratio = 4'd1;
        fill(12, 0);
        uc_sent = 0;
        for (int c = 0; c < 12; c++) step(1'b1, 1'b1, 1'b1);
        chk(uc_sent == 12, "R6", "unicast sent every slot with multicast empty",
            32'(uc_sent), 32'd12);
        drain();

        // constrained random phases
        rand_phase(3, 1500, 80, 85);
        rand_phase(1, 1500, 60, 70);
        rand_phase(0, 1000, 90, 60);
        rand_phase(7, 1500, 95, 95);
        rand_phase(2, 1500, 50, 50);

        finish_run();
    end

endmodule